// File: doc/BRIEF.md
# Reset and Boot-Configuration Controller

This block produces the internal system reset of a chip. It filters an asynchronous active-low reset pin and merges that pin with software and watchdog reset requests. It holds the internal reset for a fixed settling window after the last source goes away. It also drives an active-low reset-indication output for the board. The rules for asserting and releasing that output depend on which source caused the reset.

On the clock edge that ends a reset, the block captures the boot configuration from device pins. Which pins it captures depends on the external-access pin. It then reports whether execution should begin from external memory or from internal program memory. A cause code records the source of the most recent reset, and software can read it after reset ends.

A separate power-on reset input (`por_n`), driven by the supply monitor, clears the controller itself. Power-on counts as a reset with no recorded cause.

Top module: `rstboot_ctrl`

## Requirements
- R1: A pin reset is accepted only when `rst_pin_n` is sampled low on FILT_CYC+1 consecutive rising edges. A low pulse spanning FILT_CYC or fewer edges leaves `sys_rst` low and `rst_cause` unchanged.
- R2: While `rst_pin_n` is low, `rst_ind_n` is low in the same cycle, with no clock edge needed.
- R3: `sys_rst` is high in the cycle after `sw_rst_req` or `wdt_rst_req` is sampled high.
- R4: `sys_rst` falls HOLD_CYC+1 edges after the last edge at which any source was active. For a soft request this is HOLD_CYC+1 edges after the edge that sampled it. For the pin it is HOLD_CYC+3 edges after the pin returns high, because of the two synchroniser stages. After power-on it is HOLD_CYC+1 edges after `por_n` rises.
- R5: A software or watchdog reset drives `rst_ind_n` low at the same edge that raises `sys_rst`, but only when `ind_on_soft`=1. When `ind_on_soft`=0, `rst_ind_n` stays high through that reset.
- R6: A one-cycle pulse on `init_done_cmd` or on `ind_sw_release` releases `rst_ind_n` (high after the next edge) while `sys_rst` is low. Both pulses are ignored while `sys_rst` is high.
- R7: With `ind_auto_rel`=1, `rst_ind_n` is released at the same edge at which `sys_rst` falls.
- R8: When `ext_access_pin` is low at the edge ending reset, `boot_ext`=1 and `boot_cfg` = {`bus_cfg_pins`, `rd_pin`}, with `rd_pin` in bit 0.
- R9: When `ext_access_pin` is high at that edge, `boot_ext`=0. `boot_cfg` then holds bit 0 = `wr_pin`, bit 1 = `ale_pin`, bit 2 = `rd_pin`, and all higher bits are 0.
- R10: `boot_ext` and `boot_cfg` change only at the edge on which `sys_rst` falls. Pin changes at any other time have no effect.
- R11: `rst_cause` is updated at every edge where a source is active, using the encoding 0 = none (power-on), 1 = pin, 2 = software, 3 = watchdog. When sources coincide, priority is pin, then watchdog, then software. The value holds after reset ends.
- R12: While `por_n` is low, the outputs are `sys_rst`=1, `rst_ind_n`=0, `rst_cause`=0, `boot_ext`=0 and `boot_cfg`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_n | input | 1 | Asynchronous external reset pin, active low |
| sw_rst_req | input | 1 | Software reset request |
| wdt_rst_req | input | 1 | Watchdog reset request |
| ind_on_soft | input | 1 | Assert indication on software/watchdog resets |
| ind_auto_rel | input | 1 | Release indication when reset ends |
| ind_sw_release | input | 1 | Software release of indication |
| init_done_cmd | input | 1 | End-of-initialisation command |
| ext_access_pin | input | 1 | External-access selection pin |
| bus_cfg_pins | input | BUS_W | Data-bus pins used as configuration |
| rd_pin | input | 1 | Read-strobe pin level |
| ale_pin | input | 1 | Address-latch pin level |
| wr_pin | input | 1 | Write-strobe pin level |
| sys_rst | output | 1 | Internal reset, active high |
| rst_ind_n | output | 1 | Reset-indication output, active low |
| rst_cause | output | 2 | Cause of last reset |
| boot_ext | output | 1 | 1 = boot from external memory |
| boot_cfg | output | BUS_W+1 | Latched boot configuration |

## Verification
A filter counter that restarts wrongly either accepts a pin pulse spanning FILT_CYC edges or misses one spanning FILT_CYC+1. In both cases `sys_rst` and `rst_cause` show the error within a few cycles. An off-by-one in the settling counter moves the falling edge of `sys_rst` by one cycle, and the edge-count checks catch that exactly. A capture strobe that fires at the wrong time shows up as `boot_cfg` holding pre-exit pin values, or changing after reset has ended. A wrong release path leaves `rst_ind_n` low when it should be high, or high when it should be low, at the first sample after the command.

// File: rtl/rstboot_pkg.sv
package rstboot_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_PIN  = 2'd1,
        CAUSE_SW   = 2'd2,
        CAUSE_WDT  = 2'd3
    } rst_cause_e;
endpackage

// File: rtl/rstboot_pin_filter.sv
// Synchronises the reset pin and requires a run of low samples before
// declaring a pin reset; any high sample restarts the run.
module rstboot_pin_filter #(
    parameter int FILT_CYC    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n,
    output logic pin_active
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(FILT_CYC);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
    } filt_t;

    filt_t st_d, st_q;
    logic  pin_s;

    assign pin_s = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_n};
        if (pin_s) begin
            st_d.cnt = CNT_LOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.sync <= '1;
            st_q.cnt  <= CNT_LOAD;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_active = !pin_s && (st_q.cnt == '0);
endmodule

// File: rtl/rstboot_seq.sv
// Reset sequencer: settling window, cause record, indication state.
module rstboot_seq
    import rstboot_pkg::*;
#(
    parameter int HOLD_CYC = 8
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       pin_active,
    input  logic       sw_req,
    input  logic       wdt_req,
    input  logic       ind_on_soft,
    input  logic       ind_auto_rel,
    input  logic       ind_sw_release,
    input  logic       init_done_cmd,
    output logic       in_rst,
    output logic       ind_hold,
    output logic       exit_strobe,
    output rst_cause_e cause
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_CYC);

    typedef struct packed {
        logic        in_rst;
        logic [HW-1:0] hold;
        logic        ind;
        rst_cause_e  cause;
    } seq_t;

    seq_t st_d, st_q;
    logic soft_req;
    logic any_src;
    logic leaving;

    assign soft_req = sw_req | wdt_req;
    assign any_src  = pin_active | soft_req;
    assign leaving  = st_q.in_rst && !any_src && (st_q.hold == '0);

    always_comb begin
        st_d = st_q;
        // settling window
        if (any_src) begin
            st_d.in_rst = 1'b1;
            st_d.hold   = HOLD_LOAD;
        end else if (st_q.in_rst) begin
            if (st_q.hold == '0) begin
                st_d.in_rst = 1'b0;
            end else begin
                st_d.hold = st_q.hold - 1'b1;
            end
        end
        // cause record with fixed priority
        if (pin_active) begin
            st_d.cause = CAUSE_PIN;
        end else if (wdt_req) begin
            st_d.cause = CAUSE_WDT;
        end else if (sw_req) begin
            st_d.cause = CAUSE_SW;
        end
        // indication: set beats release, release only outside reset
        if (pin_active || (soft_req && ind_on_soft)) begin
            st_d.ind = 1'b1;
        end else if (st_q.in_rst) begin
            if (leaving && ind_auto_rel) begin
                st_d.ind = 1'b0;
            end
        end else if (init_done_cmd || ind_sw_release) begin
            st_d.ind = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.in_rst <= 1'b1;
            st_q.hold   <= HOLD_LOAD;
            st_q.ind    <= 1'b1;
            st_q.cause  <= CAUSE_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_rst      = st_q.in_rst;
    assign ind_hold    = st_q.ind;
    assign exit_strobe = leaving;
    assign cause       = st_q.cause;
endmodule

// File: rtl/rstboot_cfg_latch.sv
// Captures boot configuration on the edge that ends reset.
module rstboot_cfg_latch #(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             capture,
    input  logic             ext_access_pin,
    input  logic [BUS_W-1:0] bus_pins,
    input  logic             rd_pin,
    input  logic             ale_pin,
    input  logic             wr_pin,
    output logic             boot_ext,
    output logic [BUS_W:0]   boot_cfg
);
    localparam int CFG_W = BUS_W + 1;

    typedef struct packed {
        logic             ext;
        logic [CFG_W-1:0] cfg;
    } cfg_t;

    cfg_t st_d, st_q;
    logic [CFG_W-1:0] int_sel;

    always_comb begin
        int_sel      = '0;
        int_sel[2:0] = {rd_pin, ale_pin, wr_pin};
    end

    always_comb begin
        st_d = st_q;
        if (capture) begin
            st_d.ext = !ext_access_pin;
            st_d.cfg = ext_access_pin ? int_sel : {bus_pins, rd_pin};
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign boot_ext = st_q.ext;
    assign boot_cfg = st_q.cfg;
endmodule

// File: rtl/rstboot_ctrl.sv
module rstboot_ctrl
    import rstboot_pkg::*;
#(
    parameter int FILT_CYC = 5,
    parameter int HOLD_CYC = 8,
    parameter int BUS_W    = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_pin_n,
    input  logic             sw_rst_req,
    input  logic             wdt_rst_req,
    input  logic             ind_on_soft,
    input  logic             ind_auto_rel,
    input  logic             ind_sw_release,
    input  logic             init_done_cmd,
    input  logic             ext_access_pin,
    input  logic [BUS_W-1:0] bus_cfg_pins,
    input  logic             rd_pin,
    input  logic             ale_pin,
    input  logic             wr_pin,
    output logic             sys_rst,
    output logic             rst_ind_n,
    output logic [1:0]       rst_cause,
    output logic             boot_ext,
    output logic [BUS_W:0]   boot_cfg
);
    logic       pin_active;
    logic       ind_hold;
    logic       exit_strobe;
    rst_cause_e cause;

    rstboot_pin_filter #(.FILT_CYC(FILT_CYC), .SYNC_STAGES(2)) u_filt (
        .clk        (clk),
        .por_n      (por_n),
        .pin_n      (rst_pin_n),
        .pin_active (pin_active)
    );

    rstboot_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
        .clk            (clk),
        .por_n          (por_n),
        .pin_active     (pin_active),
        .sw_req         (sw_rst_req),
        .wdt_req        (wdt_rst_req),
        .ind_on_soft    (ind_on_soft),
        .ind_auto_rel   (ind_auto_rel),
        .ind_sw_release (ind_sw_release),
        .init_done_cmd  (init_done_cmd),
        .in_rst         (sys_rst),
        .ind_hold       (ind_hold),
        .exit_strobe    (exit_strobe),
        .cause          (cause)
    );

    rstboot_cfg_latch #(.BUS_W(BUS_W)) u_cfg (
        .clk            (clk),
        .por_n          (por_n),
        .capture        (exit_strobe),
        .ext_access_pin (ext_access_pin),
        .bus_pins       (bus_cfg_pins),
        .rd_pin         (rd_pin),
        .ale_pin        (ale_pin),
        .wr_pin         (wr_pin),
        .boot_ext       (boot_ext),
        .boot_cfg       (boot_cfg)
    );

    // pin low reaches the indication output without a clock edge
    assign rst_ind_n = rst_pin_n & ~ind_hold;
    assign rst_cause = cause;
endmodule

// File: rtl/rstboot_ctrl_chk.sv
module rstboot_ctrl_chk #(
    parameter int BUS_W = 8
) (
    input logic           clk,
    input logic           por_n,
    input logic           rst_pin_n,
    input logic           sw_rst_req,
    input logic           wdt_rst_req,
    input logic           ind_on_soft,
    input logic           ext_access_pin,
    input logic           sys_rst,
    input logic           rst_ind_n,
    input logic           boot_ext,
    input logic [BUS_W:0] boot_cfg
);
    AST_PIN_IND_LOW: assert property (@(posedge clk) disable iff (!por_n)
        !rst_pin_n |-> !rst_ind_n); // R2

    AST_SOFT_ENTERS: assert property (@(posedge clk) disable iff (!por_n)
        (sw_rst_req || wdt_rst_req) |=> sys_rst); // R3

    AST_SOFT_IND_SET: assert property (@(posedge clk) disable iff (!por_n)
        ((sw_rst_req || wdt_rst_req) && ind_on_soft) |=> !rst_ind_n); // R5

    AST_EXIT_SELECT: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sys_rst) |-> (boot_ext == !$past(ext_access_pin))); // R8

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst && !$past(sys_rst)) |-> ($stable(boot_cfg) && $stable(boot_ext))); // R10
endmodule

bind rstboot_ctrl rstboot_ctrl_chk #(.BUS_W(BUS_W)) u_chk (
    .clk            (clk),
    .por_n          (por_n),
    .rst_pin_n      (rst_pin_n),
    .sw_rst_req     (sw_rst_req),
    .wdt_rst_req    (wdt_rst_req),
    .ind_on_soft    (ind_on_soft),
    .ext_access_pin (ext_access_pin),
    .sys_rst        (sys_rst),
    .rst_ind_n      (rst_ind_n),
    .boot_ext       (boot_ext),
    .boot_cfg       (boot_cfg)
);

// File: tb/tb_rstboot_ctrl.sv
`timescale 1ns/1ps
module tb_rstboot_ctrl;
    localparam int FILT_CYC = 5;
    localparam int HOLD_CYC = 8;
    localparam int BUS_W    = 8;

    logic             clk = 1'b0;
    logic             por_n = 1'b0;
    logic             rst_pin_n = 1'b1;
    logic             sw_rst_req = 1'b0;
    logic             wdt_rst_req = 1'b0;
    logic             ind_on_soft = 1'b0;
    logic             ind_auto_rel = 1'b0;
    logic             ind_sw_release = 1'b0;
    logic             init_done_cmd = 1'b0;
    logic             ext_access_pin = 1'b1;
    logic [BUS_W-1:0] bus_cfg_pins = '0;
    logic             rd_pin = 1'b1;
    logic             ale_pin = 1'b0;
    logic             wr_pin = 1'b1;
    logic             sys_rst;
    logic             rst_ind_n;
    logic [1:0]       rst_cause;
    logic             boot_ext;
    logic [BUS_W:0]   boot_cfg;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk; // 50 MHz

    rstboot_ctrl #(.FILT_CYC(FILT_CYC), .HOLD_CYC(HOLD_CYC), .BUS_W(BUS_W)) dut (.*);

    typedef struct packed {
        logic             ext;
        logic [BUS_W-1:0] bus;
        logic             rd;
        logic             ale;
        logic             wr;
        logic             exp_ext;
        logic [BUS_W:0]   exp_cfg;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{1'b0, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b1, 9'h14A},
        '{1'b0, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b1, 9'h079},
        '{1'b1, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 9'h006},
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 9'h001}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // counts rising edges until sys_rst is seen low
    task automatic wait_exit(output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (sys_rst && n < 1000);
    endtask

    task automatic soft_pulse(input bit sw, input bit wdt);
        @(negedge clk);
        sw_rst_req = sw;
        wdt_rst_req = wdt;
        tick();
    endtask

    task automatic soft_drop();
        @(negedge clk);
        sw_rst_req = 1'b0;
        wdt_rst_req = 1'b0;
    endtask

    task automatic pulse_rel(input bit einit, input bit swr);
        @(negedge clk);
        init_done_cmd = einit;
        ind_sw_release = swr;
        @(negedge clk);
        init_done_cmd = 1'b0;
        ind_sw_release = 1'b0;
        #2;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        // R12: power-on state
        #25;
        chk(sys_rst == 1'b1, "R12 sys_rst", sys_rst, 1);
        chk(rst_ind_n == 1'b0, "R12 rst_ind_n", rst_ind_n, 0);
        chk(rst_cause == 2'd0, "R12 rst_cause", rst_cause, 0);
        chk(boot_ext == 1'b0 && boot_cfg == '0, "R12 boot", boot_cfg, 0);

        @(negedge clk);
        por_n = 1'b1;
        wait_exit(n);
        chk(n == HOLD_CYC + 1, "R4 por exit edges", n, HOLD_CYC + 1);
        chk(boot_ext == 1'b0 && boot_cfg == 9'h005, "R9 por boot_cfg", boot_cfg, 9'h005);
        chk(rst_ind_n == 1'b0, "R6 ind held after por", rst_ind_n, 0);
        pulse_rel(1'b1, 1'b0);
        chk(rst_ind_n == 1'b1, "R6 init_done releases", rst_ind_n, 1);

        // vector table: software resets with several boot pin patterns
        foreach (VECS[i]) begin
            @(negedge clk);
            ext_access_pin = VECS[i].ext;
            bus_cfg_pins   = VECS[i].bus;
            rd_pin  = VECS[i].rd;
            ale_pin = VECS[i].ale;
            wr_pin  = VECS[i].wr;
            soft_pulse(1'b1, 1'b0);
            chk(sys_rst == 1'b1, "R3 sw entry", sys_rst, 1);
            chk(rst_ind_n == 1'b1, "R5 ind off for soft", rst_ind_n, 1);
            soft_drop();
            wait_exit(n);
            chk(n == HOLD_CYC + 1, "R4 sw exit edges", n, HOLD_CYC + 1);
            chk(boot_ext == VECS[i].exp_ext, "R8/R9 boot_ext", boot_ext, VECS[i].exp_ext);
            chk(boot_cfg == VECS[i].exp_cfg, "R8/R9 boot_cfg", boot_cfg, VECS[i].exp_cfg);
            chk(rst_cause == 2'd2, "R11 cause sw", rst_cause, 2);
        end

        // R10: pins changed after exit have no effect
        @(negedge clk);
        ext_access_pin = 1'b0;
        bus_cfg_pins = 8'h5A;
        rd_pin = 1'b1;
        repeat (3) tick();
        chk(boot_ext == 1'b0 && boot_cfg == 9'h001, "R10 cfg frozen", boot_cfg, 9'h001);

        // R5 + R6: watchdog with indication, releases ignored during reset
        @(negedge clk);
        ind_on_soft = 1'b1;
        soft_pulse(1'b0, 1'b1);
        chk(rst_ind_n == 1'b0, "R5 ind on for wdt", rst_ind_n, 0);
        chk(rst_cause == 2'd3, "R11 cause wdt", rst_cause, 3);
        soft_drop();
        pulse_rel(1'b1, 1'b1);
        chk(sys_rst == 1'b1, "R6 still in reset", sys_rst, 1);
        wait_exit(n);
        chk(rst_ind_n == 1'b0, "R6 release ignored in reset", rst_ind_n, 0);
        chk(boot_ext == 1'b1 && boot_cfg == 9'h0B5, "R8 boot after wdt", boot_cfg, 9'h0B5);
        pulse_rel(1'b0, 1'b1);
        chk(rst_ind_n == 1'b1, "R6 sw release", rst_ind_n, 1);

        // R11: simultaneous requests, watchdog wins over software
        soft_pulse(1'b1, 1'b1);
        chk(rst_cause == 2'd3, "R11 wdt over sw", rst_cause, 3);
        soft_drop();
        wait_exit(n);

        // R7: automatic release at end of reset
        @(negedge clk);
        ind_auto_rel = 1'b1;
        soft_pulse(1'b1, 1'b0);
        chk(rst_ind_n == 1'b0, "R7 ind set", rst_ind_n, 0);
        soft_drop();
        wait_exit(n);
        chk(rst_ind_n == 1'b1, "R7 auto release at exit", rst_ind_n, 1);
        chk(rst_cause == 2'd2, "R11 cause sw", rst_cause, 2);

        // R1/R2: short pin pulse rejected
        @(negedge clk);
        ind_auto_rel = 1'b0;
        rst_pin_n = 1'b0;
        #1;
        chk(rst_ind_n == 1'b0, "R2 ind follows pin", rst_ind_n, 0);
        repeat (FILT_CYC - 1) @(negedge clk);
        rst_pin_n = 1'b1;
        repeat (6) tick();
        chk(sys_rst == 1'b0, "R1 short pulse no reset", sys_rst, 0);
        chk(rst_cause == 2'd2, "R1 cause unchanged", rst_cause, 2);
        chk(rst_ind_n == 1'b1, "R1 ind back high", rst_ind_n, 1);

        // R1/R4/R11: long pin pulse accepted
        @(negedge clk);
        rst_pin_n = 1'b0;
        repeat (FILT_CYC + 3) @(negedge clk);
        #2;
        chk(sys_rst == 1'b1, "R1 long pulse resets", sys_rst, 1);
        chk(rst_cause == 2'd1, "R11 cause pin", rst_cause, 1);
        @(negedge clk);
        rst_pin_n = 1'b1;
        wait_exit(n);
        chk(n == HOLD_CYC + 3, "R4 pin exit edges", n, HOLD_CYC + 3);
        chk(rst_ind_n == 1'b0, "R6 ind held after pin", rst_ind_n, 0);
        pulse_rel(1'b1, 1'b0);
        chk(rst_ind_n == 1'b1, "R6 init_done after pin", rst_ind_n, 1);

        // R1: pulse spanning exactly FILT_CYC+1 edges is accepted
        @(negedge clk);
        rst_pin_n = 1'b0;
        repeat (FILT_CYC + 1) @(negedge clk);
        rst_pin_n = 1'b1;
        tick();
        tick();
        chk(sys_rst == 1'b1, "R1 minimum accepted pulse", sys_rst, 1);
        wait_exit(n);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule